// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block runs one multi-channel pass of a successive-approximation converter. Software sets a 3-bit first channel, a 3-bit last channel and a 4-bit divider code, then pulses start. The block derives a conversion-slot tick from its clock with a free-running power-of-two divider. It walks the channel index upward from the first channel to the last, wrapping modulo eight, and handles one channel per slot.

For a populated channel (0 to 5) the block issues a one-cycle request with the channel number to an external converter. It then waits for the converter's ready pulse and stores the 10-bit sample right-justified in a 16-bit result. Channels 6 and 7 have no analog input. They still use a slot, but no request is made and a zero result is stored. Every stored result comes with a one-cycle valid strobe and its channel number. A busy flag covers the whole pass, and a one-cycle done pulse marks its end.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy_o, done_o, conv_req_o and res_valid_o are 0, and result_o, res_ch_o, cur_ch_o and conv_ch_o are 0.
- R2: A free-running counter starts at 0 after reset and advances every clock. Slot ticks occur on the clock edges where its low code+1 bits are all ones, so the tick period is 2^(code+1) clocks (code 0 gives 2, code 14 gives 32768). Each channel slot begins on a tick.
- R3: Divider code 15 is reserved and behaves exactly like code 14.
- R4: A start pulse while idle latches the first and last channel and raises busy_o on that clock edge. A start pulse while busy_o is high has no effect.
- R5: Channels are visited in the order first, first+1, ... up to last, with increments modulo 8. When first equals last, exactly one channel is handled. cur_ch_o shows the channel being handled.
- R6: For channels 0 to 5, conv_req_o is high for exactly one cycle, starting on the edge of the slot tick, with conv_ch_o equal to the channel. The block then waits for conv_rdy_i.
- R7: On the edge where conv_rdy_i is seen after a request, result_o takes {6'b0, conv_data_i}.
- R8: For channels 6 and 7, no request is issued. On the edge of the slot tick, result_o becomes 16'h0000.
- R9: Every result write raises res_valid_o for one cycle, with res_ch_o equal to the channel written.
- R10: On the edge that writes the last channel's result, busy_o falls and done_o pulses high for one cycle.
- R11: conv_rdy_i has no effect unless the block is waiting after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-pass pulse |
| start_ch_i | input | 3 | First channel of the pass |
| end_ch_i | input | 3 | Last channel of the pass |
| div_code_i | input | 4 | Slot divider code, period 2^(code+1) |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_ch_o | output | 3 | Channel for the converter |
| conv_rdy_i | input | 1 | Converter ready pulse |
| conv_data_i | input | 10 | Converter sample |
| result_o | output | 16 | Last stored result |
| res_valid_o | output | 1 | Result write strobe |
| res_ch_o | output | 3 | Channel of the stored result |
| cur_ch_o | output | 3 | Channel being handled |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Pass finished pulse |

## Verification
The hardest case to reach is a wrapped pass that crosses the empty channels 6 and 7 while the slot divider is not at its fastest setting. In that case the zero writes land on tick edges and the converter writes land on ready edges, so the two interleave. The stimulus runs a first channel of 4 with a last channel of 1 at a nonzero code, with converter latencies that vary per run. A cycle-accurate reference in the bench checks every output on every clock. Stray ready pulses and a start pulse issued in the middle of a pass check that inputs which must be ignored leave the walk unchanged.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_CONV = 2'd2
  } scan_state_e;
endpackage

// File: rtl/adc_scan_prescaler.sv
module adc_scan_prescaler #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int CNT_W = MAX_CODE + 1;
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  mask;
  logic [CODE_W-1:0] code_eff;

  // reserved codes fall back to the slowest legal divider
  assign code_eff = (code_i > MAX_C) ? MAX_C : code_i;

  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask[g] = (code_eff >= CODE_W'(g));
  end

  assign tick_o = &(cnt_q | ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_scan_walker.sv
module adc_scan_walker
  import adc_scan_pkg::*;
#(
  parameter int CH_W       = 3,
  parameter int NUM_INPUTS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  logic [CH_W-1:0] end_ch_i,
  input  logic            tick_i,
  input  logic            conv_rdy_i,
  output logic            conv_req_o,
  output logic [CH_W-1:0] cur_ch_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            wr_o,
  output logic            wr_zero_o
);
  localparam logic [CH_W:0] NUM_L = (CH_W+1)'(NUM_INPUTS);

  scan_state_e     state_q;
  logic [CH_W-1:0] cur_q, end_q;
  logic            req_q, busy_q, done_q;
  logic            populated, last;

  assign populated = ({1'b0, cur_q} < NUM_L);
  assign last      = (cur_q == end_q);

  always_comb begin
    wr_o      = 1'b0;
    wr_zero_o = 1'b0;
    case (state_q)
      ST_SLOT: if (tick_i && !populated) begin
        wr_o      = 1'b1;
        wr_zero_o = 1'b1;
      end
      ST_CONV: if (conv_rdy_i) wr_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q   <= start_ch_i;
          end_q   <= end_ch_i;
          busy_q  <= 1'b1;
          state_q <= ST_SLOT;
        end
        ST_SLOT: if (tick_i && populated) begin
          req_q   <= 1'b1;
          state_q <= ST_CONV;
        end
        default: ;
      endcase
      if (wr_o) begin
        if (last) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          cur_q   <= cur_q + 1'b1;  // wraps modulo 2^CH_W
          state_q <= ST_SLOT;
        end
      end
    end
  end

  assign conv_req_o = req_q;
  assign cur_ch_o   = cur_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
endmodule

// File: rtl/adc_scan_capture.sv
module adc_scan_capture #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10,
  parameter int RES_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              zero_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [RES_W-1:0]  result_o,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o
);
  localparam int PAD_W = RES_W - DATA_W;

  logic [RES_W-1:0] res_q;
  logic             vld_q;
  logic [CH_W-1:0]  ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
      ch_q  <= '0;
    end else begin
      vld_q <= wr_i;
      if (wr_i) begin
        res_q <= zero_i ? '0 : {{PAD_W{1'b0}}, data_i};
        ch_q  <= ch_i;
      end
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
  assign ch_o     = ch_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W       = 3,
  parameter int DATA_W     = 10,
  parameter int RES_W      = 16,
  parameter int CODE_W     = 4,
  parameter int MAX_CODE   = 14,
  parameter int NUM_INPUTS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   start_ch_i,
  input  logic [CH_W-1:0]   end_ch_i,
  input  logic [CODE_W-1:0] div_code_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_rdy_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [RES_W-1:0]  result_o,
  output logic              res_valid_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic [CH_W-1:0]   cur_ch_o,
  output logic              busy_o,
  output logic              done_o
);
  logic            tick;
  logic            wr, wr_zero;
  logic [CH_W-1:0] cur_ch;

  adc_scan_prescaler #(
    .CODE_W  (CODE_W),
    .MAX_CODE(MAX_CODE)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(div_code_i),
    .tick_o(tick)
  );

  adc_scan_walker #(
    .CH_W      (CH_W),
    .NUM_INPUTS(NUM_INPUTS)
  ) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .start_ch_i(start_ch_i),
    .end_ch_i  (end_ch_i),
    .tick_i    (tick),
    .conv_rdy_i(conv_rdy_i),
    .conv_req_o(conv_req_o),
    .cur_ch_o  (cur_ch),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .wr_o      (wr),
    .wr_zero_o (wr_zero)
  );

  adc_scan_capture #(
    .CH_W  (CH_W),
    .DATA_W(DATA_W),
    .RES_W (RES_W)
  ) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .zero_i  (wr_zero),
    .ch_i    (cur_ch),
    .data_i  (conv_data_i),
    .result_o(result_o),
    .valid_o (res_valid_o),
    .ch_o    (res_ch_o)
  );

  assign conv_ch_o = cur_ch;
  assign cur_ch_o  = cur_ch;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W       = 3,
  parameter int DATA_W     = 10,
  parameter int RES_W      = 16,
  parameter int NUM_INPUTS = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             conv_req_o,
  input logic [CH_W-1:0]  conv_ch_o,
  input logic [RES_W-1:0] result_o,
  input logic             res_valid_o,
  input logic [CH_W-1:0]  res_ch_o,
  input logic             busy_o,
  input logic             done_o
);
  localparam logic [CH_W:0] NUM_L = (CH_W+1)'(NUM_INPUTS);

  p_req_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);

  p_req_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy_o);

  p_req_populated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> ({1'b0, conv_ch_o} < NUM_L));

  p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (result_o[RES_W-1:DATA_W] == '0));

  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && ({1'b0, res_ch_o} >= NUM_L)) |-> (result_o == '0));

  p_valid_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> (!res_valid_o || busy_o || done_o) || !$past(busy_o));

  p_valid_in_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(busy_o));

  p_done_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && res_valid_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .CH_W      (CH_W),
  .DATA_W    (DATA_W),
  .RES_W     (RES_W),
  .NUM_INPUTS(NUM_INPUTS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .conv_req_o (conv_req_o),
  .conv_ch_o  (conv_ch_o),
  .result_o   (result_o),
  .res_valid_o(res_valid_o),
  .res_ch_o   (res_ch_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  start_ch_i = '0;
  logic [2:0]  end_ch_i = '0;
  logic [3:0]  div_code_i = '0;
  logic        conv_rdy_i = 1'b0;
  logic [9:0]  conv_data_i = '0;
  logic        conv_req_o;
  logic [2:0]  conv_ch_o;
  logic [15:0] result_o;
  logic        res_valid_o;
  logic [2:0]  res_ch_o;
  logic [2:0]  cur_ch_o;
  logic        busy_o;
  logic        done_o;

  always #4 clk_i = ~clk_i;

  adc_scan_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .start_ch_i(start_ch_i), .end_ch_i(end_ch_i), .div_code_i(div_code_i),
    .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
    .conv_rdy_i(conv_rdy_i), .conv_data_i(conv_data_i),
    .result_o(result_o), .res_valid_o(res_valid_o), .res_ch_o(res_ch_o),
    .cur_ch_o(cur_ch_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int pass_id = 0;
  bit stray_en = 1'b0;
  bit done_seen = 1'b0;
  int order_q[$];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model (updated at each rising edge)
  int  edges = 0;
  int  m_state = 0;  // 0 idle, 1 waiting for slot, 2 waiting for converter
  int  m_cur = 0, m_end = 0;
  bit  m_req = 0, m_busy = 0, m_done = 0, m_vld = 0;
  int  m_res = 0, m_rch = 0;

  function automatic int period_of(int code);
    int c = (code > 14) ? 14 : code;  // R3
    return 1 << (c + 1);
  endfunction

  task automatic m_write(int val);
    m_res = val;
    m_vld = 1;
    m_rch = m_cur;
    if (m_cur == m_end) begin
      m_busy = 0; m_done = 1; m_state = 0;
    end else begin
      m_cur = (m_cur + 1) % 8; m_state = 1;
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges = 0; m_state = 0; m_cur = 0; m_end = 0;
      m_req = 0; m_busy = 0; m_done = 0; m_vld = 0; m_res = 0; m_rch = 0;
    end else begin
      bit tick;
      tick = ((edges + 1) % period_of(int'(div_code_i))) == 0;  // R2
      edges++;
      m_req = 0; m_done = 0; m_vld = 0;
      if (m_state == 0) begin
        if (start_i) begin
          m_cur = start_ch_i; m_end = end_ch_i; m_busy = 1; m_state = 1;
        end
      end else if (m_state == 1) begin
        if (tick) begin
          if (m_cur < 6) begin m_req = 1; m_state = 2; end
          else m_write(0);  // R8
        end
      end else begin
        if (conv_rdy_i) m_write(int'(conv_data_i));  // R7, R11
      end
    end
  end

  // ---------------- converter responder and stray ready source
  int rdy_cnt = -1;
  int pend_ch = 0;
  int ncyc = 0;
  always @(negedge clk_i) begin
    ncyc++;
    conv_rdy_i <= 1'b0;
    conv_data_i <= 10'h155;
    if (rdy_cnt == 0) begin
      conv_rdy_i <= 1'b1;
      conv_data_i <= 10'((pend_ch * 97 + 13 + pass_id * 211) & 10'h3ff);
      rdy_cnt = -1;
    end else if (rdy_cnt > 0) rdy_cnt--;
    if (conv_req_o) begin
      rdy_cnt = lat;
      pend_ch = conv_ch_o;
    end else if (stray_en && rdy_cnt < 0 && (ncyc % 3 == 0)) begin
      conv_rdy_i <= 1'b1;  // R11 stray pulse
      conv_data_i <= 10'h3c3;
    end
  end

  // ---------------- per-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R6", "conv_req_o", conv_req_o, m_req);  // R2 slot timing
      if (m_req) chk("R6", "conv_ch_o", conv_ch_o, m_cur);
      chk("R7", "result_o", result_o, m_res);
      chk("R9", "res_valid_o", res_valid_o, m_vld);
      chk("R9", "res_ch_o", res_ch_o, m_rch);
      chk("R10", "busy_o", busy_o, m_busy);
      chk("R10", "done_o", done_o, m_done);
      chk("R5", "cur_ch_o", cur_ch_o, m_cur);
      if (conv_req_o) chk("R8", "request on empty channel", int'(conv_ch_o >= 3'd6), 0);
      if (res_valid_o) begin
        if (res_ch_o >= 3'd6) chk("R8", "empty channel result", result_o, 0);
        if (order_q.size() == 0) chk("R5", "unexpected write", 1, 0);
        else chk("R5", "visit order", res_ch_o, order_q.pop_front());
      end
      if (done_o) done_seen = 1'b1;
    end
  end

  task automatic run_pass(int s, int e, int code, int l, int mid);
    int c;
    int waited;
    pass_id++;
    lat = l;
    done_seen = 1'b0;
    order_q.delete();
    c = s;
    order_q.push_back(c);
    while (c != e) begin c = (c + 1) % 8; order_q.push_back(c); end
    @(negedge clk_i);
    start_ch_i = 3'(s); end_ch_i = 3'(e); div_code_i = 4'(code); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R4", "busy after start", busy_o, 1);
    waited = 0;
    while (!done_seen && waited < 70000) begin
      @(negedge clk_i);
      waited++;
      if (mid != 0 && waited == 3) begin
        start_ch_i = 3'(e); end_ch_i = 3'(e);  // R4 start while busy
        start_i = 1'b1;
      end else start_i = 1'b0;
    end
    chk("R10", "pass completed", done_seen, 1);
    chk("R5", "all channels visited", order_q.size(), 0);
    if (code >= 14) chk("R3", "slow divider wait", int'(waited >= 16384), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1", "busy_o", busy_o, 0);
    chk("R1", "done_o", done_o, 0);
    chk("R1", "conv_req_o", conv_req_o, 0);
    chk("R1", "res_valid_o", res_valid_o, 0);
    chk("R1", "result_o", result_o, 0);
    chk("R1", "cur_ch_o", cur_ch_o, 0);
    chk("R1", "res_ch_o", res_ch_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_pass(2, 2, 0, 0, 0);   // single channel
    run_pass(0, 3, 1, 2, 0);   // ascending
    run_pass(4, 1, 2, 1, 0);   // wrap through empty channels
    run_pass(6, 6, 0, 0, 0);   // empty channel alone
    run_pass(5, 7, 3, 4, 1);   // start ignored mid pass
    stray_en = 1'b1;           // R11 stray pulses idle and between slots
    repeat (12) begin
      @(negedge clk_i);
      chk("R11", "idle stray ignored", res_valid_o, 0);
    end
    run_pass(1, 0, 1, 3, 0);   // full 8-slot wrap with strays
    stray_en = 1'b0;
    run_pass(7, 7, 15, 0, 0);  // R3 reserved code
    run_pass(3, 3, 14, 1, 0);
    repeat (4) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule